// File: doc/BRIEF.md
# Direct-Mapped Write-Back Line Cache

This block is a direct-mapped cache between a word-addressed requester and a slower backing memory that moves whole lines. Each request address is split into three fields. The low bits pick a word inside a line. The bits above them pick one cache line. The remaining upper bits form a tag that is stored with the line, so the cache can tell which memory line it holds. Each line holds four consecutive words, a valid bit, a dirty bit and its tag.

A request hits when the indexed line is valid and its stored tag equals the request tag. A hit completes in the same cycle it is presented. A read returns the selected word combinationally, and a write updates only the cached word and marks the line dirty.

On a miss the requester is stalled through a request/ready handshake. If the victim line is valid and dirty, the whole line is first written back to its own memory line address. The line that was missed is then read as one transfer. On a write miss the incoming word is merged into the fetched line before it is installed. The request is then replayed from the cache and completes as a hit. The memory side is a single request/acknowledge port carrying one full line per transaction.

Top module: `dm_cache`

## Requirements
- R1: After reset every line is invalid and clean. With no request, ready_o is 1 and mem_req_o is 0, and the first access to each index is a miss.
- R2: A request hits when the line at index addr_i[4:2] is valid and its stored tag equals addr_i[7:5]. ready_o is then 1 in that same cycle, with no memory transaction. For a read, rdata_o is the word selected by addr_i[1:0].
- R3: A request whose index matches a valid line but whose tag differs is a miss, and ready_o is 0 in its first cycle.
- R4: A refill is one memory read at line address addr_i[7:2]. Word w of the line travels in bits [w*16 +: 16]. All four words are installed, so later reads of the other offsets of that line hit with the memory contents.
- R5: A write hit changes only the cached word. It starts no memory transaction, and a later read of that address returns the written value.
- R6: When the victim line is valid and dirty, a write transaction of the full line goes to line address {stored tag, index}. It completes before the refill read is issued, and the access then stalls for 1 + 2*(L+1) cycles, where L is the memory latency of the bench port.
- R7: When the victim line is invalid or clean, no write-back is issued and the access stalls for 1 + (L+1) cycles.
- R8: On a write miss the written word replaces its slot in the fetched line, and the installed line is marked dirty. Its later eviction writes back the merged line.
- R9: ready_o stays 0 from the cycle a miss is detected until the replayed access completes. mem_req_o is never 1 while ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until accepted |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Word address: tag [7:5], index [4:2], word [1:0] |
| wdata_i | input | 16 | Write data |
| ready_o | output | 1 | Access completes at this edge when req_i is 1 |
| rdata_o | output | 16 | Read word, valid while req_i and ready_o are 1 |
| mem_req_o | output | 1 | Memory transaction request, held until acknowledged |
| mem_we_o | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr_o | output | 6 | Memory line address |
| mem_wdata_o | output | 64 | Line written back |
| mem_rdata_i | input | 64 | Line read, valid with mem_ack_i |
| mem_ack_i | input | 1 | One-cycle transaction completion |

## Verification
A corrupted valid bit or tag shows at the ports in the same cycle it is used. The stall length of the next access to that index is wrong, or a memory transaction appears where none was expected, or the expected one is missing. A corrupted dirty bit shows only when its line is evicted, as a missing or extra write-back. A corrupted data word can stay hidden until the address is read, or until the line's write-back is compared against the reference model's copy of every memory word. That comparison is what exposes a lost write-miss merge.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_WBACK  = 2'd1,
    ST_FILL   = 2'd2
  } cache_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             fill_en_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             fill_dirty_i,
  input  logic             mark_dirty_i,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic sel;
    assign sel = (idx_i == IDX_W'(l));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[l] <= 1'b0;
        dirty_q[l] <= 1'b0;
      end else if (sel && fill_en_i) begin
        valid_q[l] <= 1'b1;
        dirty_q[l] <= fill_dirty_i;
      end else if (sel && mark_dirty_i) begin
        dirty_q[l] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (sel && fill_en_i) tag_q[l] <= fill_tag_i;
    end
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic                         clk_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [OFF_W-1:0]             off_i,
  input  logic                         fill_en_i,
  input  logic [(DATA_W<<OFF_W)-1:0]   fill_line_i,
  input  logic                         word_we_i,
  input  logic [DATA_W-1:0]            word_i,
  output logic [DATA_W-1:0]            word_o,
  output logic [(DATA_W<<OFF_W)-1:0]   line_o
);
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;

  logic [WORDS-1:0][DATA_W-1:0] line_q [LINES];

  always_ff @(posedge clk_i) begin
    if (fill_en_i)      line_q[idx_i]        <= fill_line_i;
    else if (word_we_i) line_q[idx_i][off_i] <= word_i;
  end

  assign word_o = line_q[idx_i][off_i];
  assign line_o = line_q[idx_i];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic         we_i,
  input  logic         hit_i,
  input  logic         victim_dirty_i,
  input  logic         mem_ack_i,
  output cache_state_e state_o,
  output logic         ready_o,
  output logic         mem_req_o,
  output logic         mem_we_o,
  output logic         fill_en_o,
  output logic         word_we_o
);
  cache_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    ready_o   = 1'b0;
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    fill_en_o = 1'b0;
    word_we_o = 1'b0;
    unique case (state_q)
      ST_LOOKUP: begin
        ready_o   = !req_i || hit_i;
        word_we_o = req_i && we_i && hit_i;
        if (req_i && !hit_i) state_d = victim_dirty_i ? ST_WBACK : ST_FILL;
      end
      ST_WBACK: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_ack_i) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          fill_en_o = 1'b1;
          state_d   = ST_LOOKUP;  // replay as a hit
        end
      end
      default: state_d = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LOOKUP;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dm_cache.sv
module dm_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              req_i,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic                              ready_o,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic                              mem_req_o,
  output logic                              mem_we_o,
  output logic [ADDR_W-OFF_W-1:0]           mem_addr_o,
  output logic [(DATA_W<<OFF_W)-1:0]        mem_wdata_o,
  input  logic [(DATA_W<<OFF_W)-1:0]        mem_rdata_i,
  input  logic                              mem_ack_i
);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WORDS  = 1 << OFF_W;
  localparam int LINE_W = DATA_W * WORDS;
  localparam int MEM_AW = ADDR_W - OFF_W;

  logic [OFF_W-1:0] req_off;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag, line_tag;
  logic             line_valid, line_dirty, hit;
  logic             fill_en, word_we;
  logic [LINE_W-1:0] fill_line;
  cache_state_e     state;

  assign req_off = addr_i[OFF_W-1:0];
  assign req_idx = addr_i[OFF_W +: IDX_W];
  assign req_tag = addr_i[ADDR_W-1 -: TAG_W];
  assign hit     = line_valid && (line_tag == req_tag);

  // write-miss merge into the fetched line
  for (genvar w = 0; w < WORDS; w++) begin : g_merge
    assign fill_line[w*DATA_W +: DATA_W] =
      (we_i && req_off == OFF_W'(w)) ? wdata_i : mem_rdata_i[w*DATA_W +: DATA_W];
  end

  cache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idx_i        (req_idx),
    .fill_en_i    (fill_en),
    .fill_tag_i   (req_tag),
    .fill_dirty_i (we_i),
    .mark_dirty_i (word_we),
    .valid_o      (line_valid),
    .dirty_o      (line_dirty),
    .tag_o        (line_tag)
  );

  cache_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
    .clk_i       (clk_i),
    .idx_i       (req_idx),
    .off_i       (req_off),
    .fill_en_i   (fill_en),
    .fill_line_i (fill_line),
    .word_we_i   (word_we),
    .word_i      (wdata_i),
    .word_o      (rdata_o),
    .line_o      (mem_wdata_o)
  );

  cache_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_i          (req_i),
    .we_i           (we_i),
    .hit_i          (hit),
    .victim_dirty_i (line_valid && line_dirty),
    .mem_ack_i      (mem_ack_i),
    .state_o        (state),
    .ready_o        (ready_o),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .fill_en_o      (fill_en),
    .word_we_o      (word_we)
  );

  assign mem_addr_o = (state == ST_WBACK) ? {line_tag, req_idx} : {req_tag, req_idx};
endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk #(
  parameter int MEM_AW = 6,
  parameter int LINE_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ack_i,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic [LINE_W-1:0] mem_wdata_o
);
  p_ready_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o);

  p_miss_launch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ready_o && !mem_req_o) |=> mem_req_o);

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_wb_line_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_ack_i) |=> $stable(mem_wdata_o));

  p_wb_then_fill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i) |=> (mem_req_o && !mem_we_o));

  p_fill_then_replay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ack_i) |=> (!mem_req_o && ready_o));
endmodule

bind dm_cache dm_cache_chk #(.MEM_AW(MEM_AW), .LINE_W(LINE_W)) u_chk (.*);

// File: tb/dm_cache_test.sv
module dm_cache_test;
  localparam int LAT = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        ready;
  logic [15:0] rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [5:0]  mem_addr;
  logic [63:0] mem_wdata, mem_rdata = '0;

  int n_run = 0, n_fail = 0, tx_wb = 0, tx_rd = 0, cnt = 0;
  bit done = 0;

  logic [15:0] exp_mem [256];
  logic [63:0] bmem [64];
  logic [2:0]  m_tag [8];
  bit          m_valid [8], m_dirty [8];
  bit          wb_pending = 0;
  logic [5:0]  exp_wb_la, exp_rf_la;
  logic [63:0] exp_wb_line;

  always #10 clk = ~clk;

  dm_cache uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  function automatic logic [15:0] init_word(int a);
    return 16'(a * 313 + 16'h1234);
  endfunction

  task automatic chk(string r, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // backing memory: fixed latency, one-cycle ack
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= 0;
      mem_ack <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      cnt <= 0;
    end else if (mem_req) begin
      if (cnt == LAT - 1) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          tx_wb++;
          chk("R6", "write-back expected", 64'(wb_pending), 64'd1);
          chk("R6", "write-back line address", 64'(mem_addr), 64'(exp_wb_la));
          chk("R8", "write-back line data", mem_wdata, exp_wb_line);
          bmem[mem_addr] = mem_wdata;
          wb_pending = 0;
        end else begin
          tx_rd++;
          chk("R6", "refill after write-back", 64'(wb_pending), 64'd0);
          chk("R4", "refill line address", 64'(mem_addr), 64'(exp_rf_la));
          mem_rdata <= bmem[mem_addr];
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  task automatic access(input logic w, input logic [7:0] a, input logic [15:0] d, input string r);
    logic [2:0] idx = a[4:2];
    logic [2:0] tg = a[7:5];
    bit hit = m_valid[idx] && m_tag[idx] == tg;
    bit dirty_victim = !hit && m_valid[idx] && m_dirty[idx];
    int exp_stall = hit ? 0 : (dirty_victim ? 1 + 2 * (LAT + 1) : 1 + (LAT + 1));
    int exp_tx = hit ? 0 : (dirty_victim ? 2 : 1);
    int tx0 = tx_wb + tx_rd;
    int stall = 0;
    if (dirty_victim) begin
      exp_wb_la = {m_tag[idx], idx};
      for (int k = 0; k < 4; k++) exp_wb_line[k*16 +: 16] = exp_mem[{m_tag[idx], idx, 2'(k)}];
    end
    wb_pending = dirty_victim;
    exp_rf_la = a[7:2];
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    while (!ready && stall < 1000) begin
      @(negedge clk);
      #1;
      stall++;
    end
    chk(r, "stall cycles", 64'(stall), 64'(exp_stall));
    if (!w) chk(hit ? "R2" : "R4", "read data", 64'(rdata), 64'(exp_mem[a]));
    @(negedge clk);
    req = 1'b0;
    chk("R9", "memory transactions", 64'(tx_wb + tx_rd - tx0), 64'(exp_tx));
    if (!hit) begin
      m_tag[idx] = tg;
      m_valid[idx] = 1;
      m_dirty[idx] = w;
    end else if (w) begin
      m_dirty[idx] = 1;
    end
    if (w) exp_mem[a] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 256; i++) exp_mem[i] = init_word(i);
    for (int l = 0; l < 64; l++)
      for (int k = 0; k < 4; k++) bmem[l][k*16 +: 16] = init_word(l * 4 + k);
    for (int i = 0; i < 8; i++) begin m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = '0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", "ready idle after reset", 64'(ready), 64'd1);
    chk("R1", "no memory request after reset", 64'(mem_req), 64'd0);

    access(0, 8'h00, 0, "R1");      // first access, clean miss
    access(0, 8'h01, 0, "R2");      // same line hits
    access(0, 8'h03, 0, "R4");
    access(1, 8'h02, 16'hBEEF, "R5"); // write hit
    access(0, 8'h02, 0, "R5");
    access(0, 8'h20, 0, "R3");      // same index, new tag: dirty eviction
    access(0, 8'h02, 0, "R7");      // clean victim, refetch written word
    access(1, 8'h45, 16'h7777, "R8"); // write miss merge
    access(0, 8'h44, 0, "R8");
    access(0, 8'h45, 0, "R8");
    access(0, 8'h05, 0, "R6");      // evicts merged dirty line
    for (int i = 2; i < 8; i++) access(0, {3'd3, 3'(i), 2'd1}, 0, "R1");

    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(lfsr[8], {1'b0, lfsr[6:0]}, lfsr ^ 16'h5A5A, "R2");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule